// File: doc/BRIEF.md
# Chopping Offset Canceller

This block drives an ADC master with a continuous stream of differential conversion requests for one selected input pair and flips the input polarity on every accepted conversion. A conversion taken with the pair in its normal orientation gives the signal plus the converter offset. The next conversion, taken with the two inputs swapped, gives the offset minus the signal. Two such conversions in a row give both quantities: half their difference is the signal with the offset removed, and half their sum is the offset on its own.

Samples are signed 12-bit bipolar codes, one LSB per millivolt. The block keeps the positive-phase sample until the matching negative-phase sample arrives. It then combines the two in 13-bit arithmetic, halves each result with an arithmetic right shift, and presents the signal and the offset together with a one-cycle strobe. If the selected pair changes between the two halves, or no positive sample is held, the negative-phase sample is dropped. Pairing then starts again from the next positive-phase conversion.

Top module: `chop_offset_canceller`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `req_o` and `valid_o` are 0 and `sig_o`/`off_o` are 0.
- R2: When `run_i` is high and no request is outstanding, `req_o` goes high on the next clock edge. It stays high until the clock edge at which `ack_i` is high, and drops on that edge.
- R3: While `req_o` is high, `cfg_o` is stable. `cfg_o[3]` is 0, meaning a differential conversion. `cfg_o[1:0]` holds the pair index that `chan_i` had at the edge where the request was raised.
- R4: `cfg_o[2]` is the polarity: 0 is normal orientation, 1 is swapped. The first request after reset is normal, and the polarity toggles on every acknowledged conversion.
- R5: A normal-phase sample followed by the swapped-phase sample of the same pair index makes `valid_o` high in the cycle after the swapped sample's acknowledge.
- R6: With P the normal sample and N the swapped sample, `sig_o` = floor((P−N)/2) and `off_o` = floor((P+N)/2). This holds over the full 12-bit input range with no overflow.
- R7: A swapped-phase sample whose pair index differs from that of the held normal sample, or that arrives with no normal sample held, produces no strobe.
- R8: `ack_i` asserted while no request is outstanding has no effect: no strobe, and no change to the polarity of the next request.
- R9: `valid_o` lasts exactly one cycle. `sig_o` and `off_o` hold their values whenever `valid_o` is low.
- R10: With `run_i` low, no new request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Keep issuing conversions while high |
| chan_i | input | 2 | Differential pair index to convert |
| req_o | output | 1 | Conversion request to the ADC master |
| cfg_o | output | 4 | Conversion code {single-ended=0, polarity, pair[1:0]} |
| ack_i | input | 1 | Conversion done; `sample_i` valid in this cycle |
| sample_i | input | 12 | Signed bipolar conversion result |
| valid_o | output | 1 | One-cycle strobe for a new result pair |
| sig_o | output | 12 | Offset-free signal, signed |
| off_o | output | 12 | Offset estimate, signed |

## Verification
The hardest case to reach from the ports is a swapped-phase conversion of a pair other than the one whose normal-phase sample is held, because the free-running alternation usually lines the pairs up. The bench steps the block one acknowledge at a time with `run_i`: it stops right after a normal sample has been taken, changes `chan_i`, and allows exactly one more conversion, during which no strobe may appear. The bench reaches the extreme-value pairs by loading scripted sample queues once the polarity is back to normal. It produces a stray acknowledge only while the block is idle.

// File: rtl/chop_pkg.sv
package chop_pkg;
  localparam int PAIR_W = 2;
  localparam int CFG_W  = PAIR_W + 2;

  typedef enum logic {
    POL_POS = 1'b0,
    POL_NEG = 1'b1
  } pol_e;

  // Field order is decoded by the ADC master: {single-ended, polarity, pair}
  typedef struct packed {
    logic              se;
    pol_e              pol;
    logic [PAIR_W-1:0] pair;
  } conv_cfg_t;
endpackage

// File: rtl/chop_sequencer.sv
module chop_sequencer
  import chop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [PAIR_W-1:0] chan_i,
  input  logic              ack_i,
  output logic              req_o,
  output conv_cfg_t         cfg_o,
  output logic              accept_o
);
  logic              busy_q, busy_d;
  pol_e              phase_q, phase_d;
  pol_e              rpol_q, rpol_d;
  logic [PAIR_W-1:0] pair_q, pair_d;

  assign accept_o = busy_q & ack_i;

  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    rpol_d  = rpol_q;
    pair_d  = pair_q;
    if (accept_o) begin
      busy_d  = 1'b0;
      phase_d = (phase_q == POL_POS) ? POL_NEG : POL_POS;
    end else if (!busy_q && run_i) begin
      busy_d = 1'b1;
      rpol_d = phase_q;
      pair_d = chan_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= POL_POS;
      rpol_q  <= POL_POS;
      pair_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
      rpol_q  <= rpol_d;
      pair_q  <= pair_d;
    end
  end

  assign req_o = busy_q;
  assign cfg_o = '{se: 1'b0, pol: rpol_q, pair: pair_q};
endmodule

// File: rtl/chop_pairer.sv
module chop_pairer
  import chop_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       accept_i,
  input  conv_cfg_t                  cfg_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic                       match_o,
  output logic signed [SAMPLE_W-1:0] pos_o
);
  logic                       have_q, have_d;
  logic [PAIR_W-1:0]          ppair_q, ppair_d;
  logic signed [SAMPLE_W-1:0] pos_q, pos_d;

  always_comb begin
    have_d  = have_q;
    ppair_d = ppair_q;
    pos_d   = pos_q;
    match_o = 1'b0;
    if (accept_i) begin
      if (cfg_i.pol == POL_POS) begin
        have_d  = 1'b1;
        ppair_d = cfg_i.pair;
        pos_d   = sample_i;
      end else begin
        match_o = have_q && (ppair_q == cfg_i.pair);
        have_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q  <= 1'b0;
      ppair_q <= '0;
      pos_q   <= '0;
    end else begin
      have_q  <= have_d;
      ppair_q <= ppair_d;
      pos_q   <= pos_d;
    end
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/chop_demod.sv
module chop_demod #(
  parameter int SAMPLE_W = 12
) (
  input  logic signed [SAMPLE_W-1:0] pos_i,
  input  logic signed [SAMPLE_W-1:0] neg_i,
  output logic signed [SAMPLE_W-1:0] sig_o,
  output logic signed [SAMPLE_W-1:0] off_o
);
  localparam int WIDE_W = SAMPLE_W + 1;

  logic signed [WIDE_W-1:0] pos_w, neg_w, dif_w, sum_w;

  always_comb begin
    pos_w = {pos_i[SAMPLE_W-1], pos_i};
    neg_w = {neg_i[SAMPLE_W-1], neg_i};
    dif_w = pos_w - neg_w;
    sum_w = pos_w + neg_w;
  end

  // Dropping the LSB of the widened result is the arithmetic halving.
  assign sig_o = dif_w[WIDE_W-1:1];
  assign off_o = sum_w[WIDE_W-1:1];
endmodule

// File: rtl/chop_offset_canceller.sv
module chop_offset_canceller
  import chop_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run_i,
  input  logic [PAIR_W-1:0]          chan_i,
  output logic                       req_o,
  output logic [CFG_W-1:0]           cfg_o,
  input  logic                       ack_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic                       valid_o,
  output logic signed [SAMPLE_W-1:0] sig_o,
  output logic signed [SAMPLE_W-1:0] off_o
);
  conv_cfg_t                  cfg;
  logic                       accept, match;
  logic signed [SAMPLE_W-1:0] pos_held, sig_c, off_c;
  logic                       valid_d;
  logic signed [SAMPLE_W-1:0] sig_d, off_d;

  chop_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .chan_i(chan_i), .ack_i(ack_i),
    .req_o(req_o), .cfg_o(cfg), .accept_o(accept)
  );

  chop_pairer #(.SAMPLE_W(SAMPLE_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .cfg_i(cfg),
    .sample_i(sample_i), .match_o(match), .pos_o(pos_held)
  );

  chop_demod #(.SAMPLE_W(SAMPLE_W)) u_demod (
    .pos_i(pos_held), .neg_i(sample_i), .sig_o(sig_c), .off_o(off_c)
  );

  always_comb begin
    valid_d = match;
    sig_d   = sig_o;
    off_d   = off_o;
    if (match) begin
      sig_d = sig_c;
      off_d = off_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      sig_o   <= '0;
      off_o   <= '0;
    end else begin
      valid_o <= valid_d;
      sig_o   <= sig_d;
      off_o   <= off_d;
    end
  end

  assign cfg_o = cfg;
endmodule

// File: rtl/chop_offset_canceller_chk.sv
module chop_offset_canceller_chk #(
  parameter int SAMPLE_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ack_i,
  input logic                req_o,
  input logic [3:0]          cfg_o,
  input logic                valid_o,
  input logic [SAMPLE_W-1:0] sig_o,
  input logic [SAMPLE_W-1:0] off_o
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && !ack_i |=> req_o) else $error("req dropped early"); // R2
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && ack_i |=> !req_o) else $error("req held after ack"); // R2
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && !ack_i |=> $stable(cfg_o)) else $error("cfg moved"); // R3
  AST_DIFF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> !cfg_o[3]) else $error("single-ended code"); // R3
  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(req_o && ack_i && cfg_o[2])) else $error("strobe w/o swapped ack"); // R5
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o) else $error("strobe too long"); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(sig_o) && $stable(off_o)) else $error("outputs moved"); // R9
endmodule

bind chop_offset_canceller chop_offset_canceller_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .req_o(req_o), .cfg_o(cfg_o),
  .valid_o(valid_o), .sig_o(sig_o), .off_o(off_o)
);

// File: tb/chop_offset_canceller_tb.sv
module chop_offset_canceller_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic run_i = 0;
  logic [1:0] chan_i = 0;
  logic req_o;
  logic [3:0] cfg_o;
  logic ack_i = 0;
  logic signed [11:0] sample_i = 0;
  logic valid_o;
  logic signed [11:0] sig_o, off_o;

  int errs = 0, checks = 0, cyc = 0;
  int lat_cfg = 1, lat_cnt = 1;
  int sig_mv = 0, off_mv = 0;
  bit stray = 0;
  int smp_q[$];

  // reference model state
  bit m_busy, m_neg, m_phase, m_have, m_valid;
  int m_pair, m_ppair, m_pos, m_sig, m_off, acc_cnt;

  always #10 clk = ~clk;

  chop_offset_canceller u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .chan_i(chan_i), .req_o(req_o),
    .cfg_o(cfg_o), .ack_i(ack_i), .sample_i(sample_i), .valid_o(valid_o),
    .sig_o(sig_o), .off_o(off_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ADC master stand-in
  always @(negedge clk) begin
    if (!rst_n) ack_i = 0;
    else if (ack_i) ack_i = 0;
    else if (req_o) begin
      if (lat_cnt <= 0) begin
        int v;
        if (smp_q.size() > 0) v = smp_q.pop_front();
        else begin
          v = cfg_o[2] ? (off_mv - sig_mv) : (off_mv + sig_mv);
          if (v > 2047) v = 2047;
          if (v < -2048) v = -2048;
        end
        sample_i = 12'(v);
        ack_i = 1;
        lat_cnt = lat_cfg;
      end else lat_cnt--;
    end else if (stray) begin
      sample_i = 12'sd1000;
      ack_i = 1;
      stray = 0;
    end
  end

  // behavioural reference, updated at the clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_neg = 0; m_phase = 0; m_have = 0; m_valid = 0;
      m_pair = 0; m_ppair = 0; m_pos = 0; m_sig = 0; m_off = 0;
    end else begin
      m_valid = 0;
      if (m_busy && ack_i) begin
        int s;
        s = $signed(sample_i);
        acc_cnt++;
        m_busy = 0;
        if (!m_neg) begin
          m_have = 1; m_pos = s; m_ppair = m_pair;
        end else begin
          if (m_have && m_ppair == m_pair) begin
            m_valid = 1;
            m_sig = (m_pos - s) >>> 1;
            m_off = (m_pos + s) >>> 1;
          end
          m_have = 0;
        end
        m_phase = !m_phase;
      end else if (!m_busy && run_i) begin
        m_busy = 1; m_pair = chan_i; m_neg = m_phase;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      chk(req_o == m_busy, "R2 req", req_o, m_busy);
      if (m_busy) begin
        chk(cfg_o[3] == 0 && cfg_o[1:0] == 2'(m_pair), "R3 cfg", cfg_o, m_pair);
        chk(cfg_o[2] == m_neg, "R4 polarity", cfg_o[2], m_neg);
      end
      chk(valid_o == m_valid, "R5/R7 strobe", valid_o, m_valid);
      if (m_valid) begin
        chk(sig_o == 12'(m_sig), "R6 signal", sig_o, m_sig);
        chk(off_o == 12'(m_off), "R6 offset", off_o, m_off);
      end else begin
        chk(sig_o == 12'(m_sig) && off_o == 12'(m_off), "R9 hold", sig_o, m_sig);
      end
    end
  end

  task automatic run_n(input int n, output int v);
    int target;
    target = acc_cnt + n;
    v = 0;
    run_i = 1;
    while (acc_cnt < target) begin
      @(negedge clk);
      if (valid_o) v++;
    end
    run_i = 0;
    repeat (2) begin
      @(negedge clk);
      if (valid_o) v++;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    finish_run();
  end

  initial begin
    int v;
    bit pol_before;
    repeat (3) @(negedge clk);
    chk(req_o == 0 && valid_o == 0 && sig_o == 0 && off_o == 0, "R1 reset", valid_o, 0);
    @(posedge clk); #2 rst_n = 1;
    @(negedge clk);
    chk(req_o == 0 && valid_o == 0, "R1 after reset", req_o, 0);

    // steady chopping on pair 0
    chan_i = 0; sig_mv = 500; off_mv = 7; lat_cfg = 1; run_i = 1;
    repeat (40) @(negedge clk);
    // free-running change of pair
    chan_i = 2; sig_mv = -1234; off_mv = -3; lat_cfg = 0;
    repeat (40) @(negedge clk);
    run_i = 0;
    repeat (6) @(negedge clk);

    // R7: normal sample of pair 1 held, then swapped conversion of pair 3
    chan_i = 1; sig_mv = 300; off_mv = 11;
    if (m_phase) run_n(1, v);
    run_n(1, v);
    chan_i = 3;
    run_n(1, v);
    chk(v == 0, "R7 mismatched pair strobes", v, 0);
    run_n(2, v);
    chk(v == 1, "R5 realigned pair strobes", v, 1);

    // R8: stray acknowledge while idle
    pol_before = m_phase;
    stray = 1;
    repeat (4) @(negedge clk);
    chk(valid_o == 0, "R8 stray ack strobe", valid_o, 0);
    run_i = 1;
    @(negedge clk);
    chk(req_o == 1 && cfg_o[2] == pol_before, "R8 polarity kept", cfg_o[2], pol_before);
    run_i = 0;
    wait (!req_o);
    @(negedge clk);

    // R10: idle with run low
    begin
      bit seen = 0;
      repeat (20) begin @(negedge clk); if (req_o) seen = 1; end
      chk(!seen, "R10 no request", seen, 0);
    end

    // R6 extremes, aligned to normal polarity
    chan_i = 2; lat_cfg = 2;
    if (m_phase) run_n(1, v);
    smp_q = '{2047, -2048, -2048, 2047, -2048, -2048, 2047, 2047, -1, 0};
    run_n(10, v);
    chk(v == 5, "R6 extreme pairs", v, 5);
    chk(sig_o == -12'sd1 && off_o == -12'sd1, "R6 last pair floor", sig_o, -1);

    // randomized latency and pair changes
    run_i = 1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 40) == 0) chan_i = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 20) == 0) lat_cfg = $urandom_range(0, 4);
      if ($urandom_range(0, 60) == 0) begin
        sig_mv = $urandom_range(0, 2000) - 1000;
        off_mv = $urandom_range(0, 60) - 30;
      end
      if ($urandom_range(0, 100) == 0) run_i = ~run_i;
    end
    run_i = 0;
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule